// File: doc/BRIEF.md
# I2C Master Packet Command Engine

This block is a single-master I2C controller that moves one byte per command. Software writes one command word, which says whether to open with a START and the 7-bit target address, whether to send one byte or receive one byte, whether a received byte is the final one, and whether to finish with a STOP. The engine runs the bit sequence on SCL and SDA and then raises a completion flag. If the target did not acknowledge, it also raises a NAK flag. Software clears both flags by writing ones to them.

A longer transfer is a chain of commands. The first command carries START. Later commands carry on without re-addressing. The command that closes the transfer carries STOP. A START issued while the bus is still owned becomes a repeated START. A command with START and no data phase sends only the address, which makes it a zero-length presence probe. The lines are driven open-drain: the block only ever pulls a line low, through its output enables. A quarter-bit divider parameter sets the bit rate.

Top module: `i2cpk_master`

## Requirements
- R1: A write to the command port is accepted only when command bit 16 is 1 and no packet is in progress. A write with bit 16 at 0, or any command written while a packet is running, is ignored.
- R2: Command bit 0 requests a START followed by the address from command bits 30:24, sent MSB first, then a R/W bit. The R/W bit is 1 when command bit 3 (receive) is set and 0 otherwise. If the bus is already owned, the START is a repeated START with no STOP before it.
- R3: Command bit 1 transmits the low byte (bits 7:0) last written to the buffer port, MSB first, and then samples the target's acknowledge.
- R4: Command bit 3 receives 8 bits, MSB first, into buffer read bits 15:8. The master answers with ACK, or with NACK when command bit 4 (last byte) is also set.
- R5: Completing any packet sets status bit 16. Writing 1 to status bit 16 clears it, and writing 0 to it has no effect.
- R6: Status bit 1 (NAK) is set together with bit 16 when the address or a transmitted byte is not acknowledged. Writing 1 to status bit 1 clears it without touching bit 16.
- R7: A command with START and neither transmit nor receive performs only the address phase and reports the target's acknowledge through R5 and R6.
- R8: Command bit 5 adds a STOP at the end of the packet, including after a NAK. After a NAK without STOP, SCL stays pulled low until the next command.
- R9: Buffer read bit 16 (bus busy) is 1 from the completion of a START until the completion of a STOP, and 0 otherwise.
- R10: After reset both line enables are off (lines released). SDA changes while SCL is released only as part of a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word |
| buf_we | input | 1 | Buffer write strobe (transmit byte) |
| buf_wdata | input | 32 | Buffer write data, bits 7:0 used |
| sts_we | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wdata | input | 32 | Status clear mask |
| sts_rdata | output | 32 | Status: bit 16 packet done, bit 1 NAK |
| buf_rdata | output | 32 | Buffer: bit 16 busy, 15:8 received byte, 7:0 transmit byte |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench pairs the engine with a behavioural target on the wired-AND bus. That target acknowledges one address, refuses the byte 0xFF, and returns an incrementing sequence on reads. A wrong R/W bit or bit order would make the target miss the address or send no read data, and a wrong last-byte answer would keep it driving the bus. The bench also covers a repeated START with no STOP before it, an address NAK with and without STOP (a missing hold would let SCL float), commands sent while busy or without the enable bit (a design that took them would start a second transfer), and clearing each status flag separately.

// File: rtl/i2cpk_pkg.sv
package i2cpk_pkg;

  // Command word fields.
  localparam int CMD_START_BIT = 0;
  localparam int CMD_TX_BIT    = 1;
  localparam int CMD_RX_BIT    = 3;
  localparam int CMD_LAST_BIT  = 4;
  localparam int CMD_STOP_BIT  = 5;
  localparam int CMD_EN_BIT    = 16;
  localparam int CMD_ADDR_LSB  = 24;
  localparam int ADDR_W        = 7;

  // Status and buffer fields.
  localparam int STS_NAK_BIT   = 1;
  localparam int STS_DONE_BIT  = 16;
  localparam int BUF_RX_LSB    = 8;
  localparam int BUF_BUSY_BIT  = 16;
  localparam int BYTE_W        = 8;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WBIT  = 2'd2,
    OP_RBIT  = 2'd3
  } bitop_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              start;
    logic              tx;
    logic              rx;
    logic              last;
    logic              stop;
  } pkt_cmd_t;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_START, SQ_ADDR, SQ_AACK, SQ_TXB,
    SQ_TACK, SQ_RXB, SQ_RACK, SQ_STOP, SQ_DONE
  } seq_st_e;

endpackage

// File: rtl/i2cpk_bitctl.sv
module i2cpk_bitctl
  import i2cpk_pkg::*;
#(
  parameter int QDIV = 63
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   op_valid,
  input  bitop_e op_kind,
  input  logic   op_bit,
  input  logic   sda_i,
  output logic   op_done,
  output logic   rx_bit,
  output logic   scl_oe,
  output logic   sda_oe
);

  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] CNT_RELOAD = CW'(QDIV - 1);

  logic          active_q, active_d;
  bitop_e        kind_q, kind_d;
  logic          bit_q, bit_d;
  logic [1:0]    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          scl_oe_q, scl_oe_d;
  logic          sda_oe_q, sda_oe_d;
  logic          rx_q, rx_d;
  logic          done_q, done_d;
  logic          sda_s1_q, sda_s2_q;

  always_comb begin
    active_d = active_q;
    kind_d   = kind_q;
    bit_d    = bit_q;
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    scl_oe_d = scl_oe_q;
    sda_oe_d = sda_oe_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    if (!active_q) begin
      if (op_valid) begin
        active_d = 1'b1;
        kind_d   = op_kind;
        bit_d    = op_bit;
        ph_d     = 2'd0;
        cnt_d    = CNT_RELOAD;
      end
    end else if (cnt_q == '0) begin
      cnt_d = CNT_RELOAD;
      ph_d  = 2'(ph_q + 2'd1);
      unique case (kind_q)
        OP_START: begin
          case (ph_q)
            2'd0: sda_oe_d = 1'b0;
            2'd1: scl_oe_d = 1'b0;
            2'd2: sda_oe_d = 1'b1;
            default: scl_oe_d = 1'b1;
          endcase
        end
        OP_STOP: begin
          case (ph_q)
            2'd0: sda_oe_d = 1'b1;
            2'd1: scl_oe_d = 1'b0;
            2'd2: sda_oe_d = 1'b0;
            default: ;
          endcase
        end
        OP_WBIT: begin
          case (ph_q)
            2'd0: sda_oe_d = ~bit_q;
            2'd1: scl_oe_d = 1'b0;
            2'd2: ;
            default: scl_oe_d = 1'b1;
          endcase
        end
        default: begin
          case (ph_q)
            2'd0: sda_oe_d = 1'b0;
            2'd1: scl_oe_d = 1'b0;
            2'd2: rx_d     = sda_s2_q;
            default: scl_oe_d = 1'b1;
          endcase
        end
      endcase
      if (ph_q == 2'd3) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      kind_q   <= OP_STOP;
      bit_q    <= 1'b0;
      ph_q     <= 2'd0;
      cnt_q    <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      rx_q     <= 1'b0;
      done_q   <= 1'b0;
      sda_s1_q <= 1'b1;
      sda_s2_q <= 1'b1;
    end else begin
      active_q <= active_d;
      kind_q   <= kind_d;
      bit_q    <= bit_d;
      ph_q     <= ph_d;
      cnt_q    <= cnt_d;
      scl_oe_q <= scl_oe_d;
      sda_oe_q <= sda_oe_d;
      rx_q     <= rx_d;
      done_q   <= done_d;
      sda_s1_q <= sda_i;
      sda_s2_q <= sda_s1_q;
    end
  end

  assign op_done = done_q;
  assign rx_bit  = rx_q;
  assign scl_oe  = scl_oe_q;
  assign sda_oe  = sda_oe_q;

  AST_SDA_STILL_WHILE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe_q && !$past(scl_oe_q) && (sda_oe_q != $past(sda_oe_q)))
      |-> (kind_q == OP_START || kind_q == OP_STOP)); // R10

endmodule

// File: rtl/i2cpk_seq.sv
module i2cpk_seq
  import i2cpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  pkt_cmd_t          cmd_in,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              op_valid,
  output bitop_e            op_kind,
  output logic              op_bit,
  input  logic              op_done,
  input  logic              rx_bit,
  output logic              pkt_done,
  output logic              pkt_nak,
  output logic              pkt_rx,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              bus_owned
);

  seq_st_e           st_q, st_d;
  pkt_cmd_t          cmd_q, cmd_d;
  logic [BYTE_W-1:0] txb_q, txb_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [2:0]        bcnt_q, bcnt_d;
  logic              pend_q, pend_d;
  logic              nak_q, nak_d;
  logic              own_q, own_d;
  logic              needs_op;

  always_comb begin
    needs_op = 1'b1;
    op_kind  = OP_WBIT;
    op_bit   = sh_q[BYTE_W-1];
    unique case (st_q)
      SQ_START: op_kind = OP_START;
      SQ_STOP:  op_kind = OP_STOP;
      SQ_ADDR, SQ_TXB: op_kind = OP_WBIT;
      SQ_RACK: begin
        op_kind = OP_WBIT;
        op_bit  = cmd_q.last;
      end
      SQ_AACK, SQ_TACK, SQ_RXB: op_kind = OP_RBIT;
      default: needs_op = 1'b0;
    endcase
  end

  assign op_valid = needs_op && !pend_q;

  always_comb begin
    st_d   = st_q;
    cmd_d  = cmd_q;
    txb_d  = txb_q;
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    nak_d  = nak_q;
    own_d  = own_q;
    pend_d = pend_q;
    if (op_valid) pend_d = 1'b1;
    if (op_done)  pend_d = 1'b0;

    unique case (st_q)
      SQ_IDLE: begin
        if (cmd_valid) begin
          cmd_d  = cmd_in;
          txb_d  = tx_byte;
          nak_d  = 1'b0;
          bcnt_d = 3'd7;
          if (cmd_in.start)     st_d = SQ_START;
          else if (cmd_in.tx) begin
            st_d = SQ_TXB;
            sh_d = tx_byte;
          end
          else if (cmd_in.rx)   st_d = SQ_RXB;
          else if (cmd_in.stop) st_d = SQ_STOP;
          else                  st_d = SQ_DONE;
        end
      end
      SQ_START: if (op_done) begin
        own_d  = 1'b1;
        sh_d   = {cmd_q.addr, cmd_q.rx};
        bcnt_d = 3'd7;
        st_d   = SQ_ADDR;
      end
      SQ_ADDR, SQ_TXB: if (op_done) begin
        sh_d = {sh_q[BYTE_W-2:0], 1'b0};
        if (bcnt_q == 3'd0) st_d = (st_q == SQ_ADDR) ? SQ_AACK : SQ_TACK;
        else bcnt_d = bcnt_q - 3'd1;
      end
      SQ_AACK: if (op_done) begin
        bcnt_d = 3'd7;
        if (rx_bit) begin
          nak_d = 1'b1;
          st_d  = cmd_q.stop ? SQ_STOP : SQ_DONE;
        end else if (cmd_q.tx) begin
          sh_d = txb_q;
          st_d = SQ_TXB;
        end else if (cmd_q.rx)   st_d = SQ_RXB;
        else if (cmd_q.stop)     st_d = SQ_STOP;
        else                     st_d = SQ_DONE;
      end
      SQ_TACK: if (op_done) begin
        if (rx_bit) nak_d = 1'b1;
        st_d = cmd_q.stop ? SQ_STOP : SQ_DONE;
      end
      SQ_RXB: if (op_done) begin
        sh_d = {sh_q[BYTE_W-2:0], rx_bit};
        if (bcnt_q == 3'd0) st_d = SQ_RACK;
        else bcnt_d = bcnt_q - 3'd1;
      end
      SQ_RACK: if (op_done) begin
        st_d = cmd_q.stop ? SQ_STOP : SQ_DONE;
      end
      SQ_STOP: if (op_done) begin
        own_d = 1'b0;
        st_d  = SQ_DONE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cmd_q  <= '0;
      txb_q  <= '0;
      sh_q   <= '0;
      bcnt_q <= 3'd0;
      pend_q <= 1'b0;
      nak_q  <= 1'b0;
      own_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      txb_q  <= txb_d;
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      pend_q <= pend_d;
      nak_q  <= nak_d;
      own_q  <= own_d;
    end
  end

  assign pkt_done  = (st_q == SQ_DONE);
  assign pkt_nak   = nak_q;
  assign pkt_rx    = cmd_q.rx;
  assign rx_byte   = sh_q;
  assign bus_owned = own_q;

  AST_CMD_IGNORED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_IDLE && cmd_valid) |=> $stable(cmd_q)); // R1

  AST_BUSY_ENDS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_q) |-> ($past(st_q) == SQ_STOP)); // R9

  AST_BUSY_BEGINS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_q) |-> ($past(st_q) == SQ_START)); // R9

endmodule

// File: rtl/i2cpk_regs.sv
module i2cpk_regs
  import i2cpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sts_clr_we,
  input  logic              clr_done,
  input  logic              clr_nak,
  input  logic              buf_we,
  input  logic [BYTE_W-1:0] buf_byte,
  input  logic              pkt_done,
  input  logic              pkt_nak,
  input  logic              pkt_rx,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              bus_owned,
  output logic [31:0]       sts_rdata,
  output logic [31:0]       buf_rdata,
  output logic [BYTE_W-1:0] tx_byte
);

  logic              done_q, done_d;
  logic              nak_q, nak_d;
  logic [BYTE_W-1:0] rxb_q, rxb_d;
  logic [BYTE_W-1:0] txb_q, txb_d;

  always_comb begin
    done_d = done_q;
    nak_d  = nak_q;
    rxb_d  = rxb_q;
    txb_d  = txb_q;
    if (sts_clr_we && clr_done) done_d = 1'b0;
    if (sts_clr_we && clr_nak)  nak_d  = 1'b0;
    if (pkt_done) begin
      done_d = 1'b1;
      if (pkt_nak) nak_d = 1'b1;
      if (pkt_rx)  rxb_d = rx_byte;
    end
    if (buf_we) txb_d = buf_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      nak_q  <= 1'b0;
      rxb_q  <= '0;
      txb_q  <= '0;
    end else begin
      done_q <= done_d;
      nak_q  <= nak_d;
      rxb_q  <= rxb_d;
      txb_q  <= txb_d;
    end
  end

  always_comb begin
    sts_rdata = '0;
    sts_rdata[STS_DONE_BIT] = done_q;
    sts_rdata[STS_NAK_BIT]  = nak_q;
    buf_rdata = '0;
    buf_rdata[BUF_BUSY_BIT] = bus_owned;
    buf_rdata[BUF_RX_LSB +: BYTE_W] = rxb_q;
    buf_rdata[BYTE_W-1:0] = txb_q;
  end

  assign tx_byte = txb_q;

  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr_we && clr_done && !pkt_done) |=> !done_q); // R5

  AST_NAK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_nak) |=> (nak_q && done_q)); // R6

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(sts_clr_we && clr_done)) |=> done_q); // R5

endmodule

// File: rtl/i2cpk_master.sv
module i2cpk_master
  import i2cpk_pkg::*;
#(
  parameter int QDIV = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        buf_we,
  input  logic [31:0] buf_wdata,
  input  logic        sts_we,
  input  logic [31:0] sts_wdata,
  output logic [31:0] sts_rdata,
  output logic [31:0] buf_rdata,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe
);

  pkt_cmd_t          cmd_dec;
  logic              cmd_valid;
  logic              op_valid, op_bit, op_done, rx_bit;
  bitop_e            op_kind;
  logic              pkt_done, pkt_nak, pkt_rx, bus_owned;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic              unused_bits;

  always_comb begin
    cmd_dec.addr  = cmd_wdata[CMD_ADDR_LSB +: ADDR_W];
    cmd_dec.start = cmd_wdata[CMD_START_BIT];
    cmd_dec.tx    = cmd_wdata[CMD_TX_BIT];
    cmd_dec.rx    = cmd_wdata[CMD_RX_BIT];
    cmd_dec.last  = cmd_wdata[CMD_LAST_BIT];
    cmd_dec.stop  = cmd_wdata[CMD_STOP_BIT];
  end

  assign cmd_valid = cmd_we && cmd_wdata[CMD_EN_BIT];

  assign unused_bits = ^{cmd_wdata[31], cmd_wdata[23:17], cmd_wdata[15:6],
                         cmd_wdata[2], buf_wdata[31:8], sts_wdata[31:17],
                         sts_wdata[15:2], sts_wdata[0]};

  i2cpk_bitctl #(.QDIV(QDIV)) u_bit (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_bit   (op_bit),
    .sda_i    (sda_i),
    .op_done  (op_done),
    .rx_bit   (rx_bit),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe)
  );

  i2cpk_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_in    (cmd_dec),
    .tx_byte   (tx_byte),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .op_bit    (op_bit),
    .op_done   (op_done),
    .rx_bit    (rx_bit),
    .pkt_done  (pkt_done),
    .pkt_nak   (pkt_nak),
    .pkt_rx    (pkt_rx),
    .rx_byte   (rx_byte),
    .bus_owned (bus_owned)
  );

  i2cpk_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sts_clr_we (sts_we),
    .clr_done   (sts_wdata[STS_DONE_BIT]),
    .clr_nak    (sts_wdata[STS_NAK_BIT]),
    .buf_we     (buf_we),
    .buf_byte   (buf_wdata[BYTE_W-1:0]),
    .pkt_done   (pkt_done),
    .pkt_nak    (pkt_nak),
    .pkt_rx     (pkt_rx),
    .rx_byte    (rx_byte),
    .bus_owned  (bus_owned),
    .sts_rdata  (sts_rdata),
    .buf_rdata  (buf_rdata),
    .tx_byte    (tx_byte)
  );

endmodule

// File: tb/sim_i2cpk_master.sv
module sim_i2cpk_master;

  localparam int QD = 4;
  localparam logic [6:0] SA  = 7'h52;
  localparam logic [6:0] BAD = 7'h11;

  logic clk, rst_n;
  logic cmd_we, buf_we, sts_we;
  logic [31:0] cmd_wdata, buf_wdata, sts_wdata, sts_rdata, buf_rdata;
  logic scl_oe, sda_oe, sl_low;
  logic scl, sda;

  assign scl = ~scl_oe;
  assign sda = ~(sda_oe | sl_low);

  i2cpk_master #(.QDIV(QD)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .sts_we(sts_we), .sts_wdata(sts_wdata),
    .sts_rdata(sts_rdata), .buf_rdata(buf_rdata), .sda_i(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural target on the bus
  int unsigned sl_state;   // 0 idle, 1 address, 2 write, 3 read
  int unsigned sl_bitn;
  logic        sl_ack, sl_match, sl_rw, sl_mack;
  logic [7:0]  sl_sh, sl_rd, sl_last_wr;
  int          sl_starts, sl_stops;

  initial begin
    sl_low = 1'b0; sl_state = 0; sl_bitn = 0; sl_ack = 1'b0; sl_match = 1'b0;
    sl_rw = 1'b0; sl_mack = 1'b0; sl_sh = 8'h00; sl_rd = 8'h00; sl_last_wr = 8'h00;
    sl_starts = 0; sl_stops = 0;
  end

  always @(negedge sda) if (scl === 1'b1 && rst_n === 1'b1) begin
    sl_starts++; sl_state = 1; sl_bitn = 0; sl_ack = 1'b0; sl_low = 1'b0;
  end

  always @(posedge sda) if (scl === 1'b1 && rst_n === 1'b1) begin
    sl_stops++; sl_state = 0; sl_low = 1'b0;
  end

  always @(posedge scl) if (rst_n === 1'b1) begin
    if ((sl_state == 1 || sl_state == 2) && !sl_ack) begin
      sl_sh = {sl_sh[6:0], sda}; sl_bitn++;
    end else if (sl_state == 3) begin
      if (!sl_ack) sl_bitn++;
      else sl_mack = sda;
    end
  end

  always @(negedge scl) if (rst_n === 1'b1) begin
    case (sl_state)
      1: if (sl_ack) begin
           sl_ack = 1'b0;
           if (sl_match) begin
             sl_state = sl_rw ? 3 : 2; sl_bitn = 0;
             sl_low = sl_rw ? ~sl_rd[7] : 1'b0;
           end else begin
             sl_state = 0; sl_low = 1'b0;
           end
         end else if (sl_bitn == 8) begin
           sl_ack = 1'b1; sl_match = (sl_sh[7:1] == SA); sl_rw = sl_sh[0];
           if (sl_match && sl_rw) sl_rd = 8'hA5;
           sl_low = sl_match;
         end
      2: if (sl_ack) begin
           sl_ack = 1'b0; sl_low = 1'b0; sl_bitn = 0;
         end else if (sl_bitn == 8) begin
           sl_ack = 1'b1; sl_last_wr = sl_sh; sl_low = (sl_sh != 8'hFF);
         end
      3: if (sl_ack) begin
           sl_ack = 1'b0;
           if (!sl_mack) begin
             sl_rd = sl_rd + 8'd1; sl_bitn = 0; sl_low = ~sl_rd[7];
           end else begin
             sl_state = 0; sl_low = 1'b0;
           end
         end else if (sl_bitn == 8) begin
           sl_ack = 1'b1; sl_low = 1'b0;
         end else begin
           sl_low = ~sl_rd[7 - sl_bitn];
         end
      default: ;
    endcase
  end

  // Checking
  int n_chk, n_err;
  logic finished;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input logic en, input logic [6:0] a,
      input logic st, input logic tx, input logic rx, input logic last, input logic sp);
    return {1'b0, a, 7'b0, en, 10'b0, sp, last, rx, 1'b0, tx, st};
  endfunction

  task automatic wr_cmd(input logic [31:0] w);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = 32'h0;
  endtask

  task automatic wr_buf(input logic [7:0] b);
    @(negedge clk); buf_we = 1'b1; buf_wdata = {24'h0, b};
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic wr_sts(input logic [31:0] m);
    @(negedge clk); sts_we = 1'b1; sts_wdata = m;
    @(negedge clk); sts_we = 1'b0; sts_wdata = 32'h0;
  endtask

  task automatic wait_done(input string tag);
    int k;
    k = 0;
    while (sts_rdata[16] !== 1'b1 && k < 5000) begin
      @(negedge clk); k++;
    end
    chk({tag, " packet done"}, {31'h0, sts_rdata[16]}, 32'h1);
  endtask

  typedef struct packed {
    logic [6:0] addr;
    logic st, tx, rx, last, sp;
    logic [7:0] txb;
    logic       nak;
    logic [7:0] rxv;
    logic       busy;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{SA,  1'b1,1'b1,1'b0,1'b0,1'b0, 8'h3C, 1'b0, 8'h00, 1'b1}, // R2 R3 start+write
    '{SA,  1'b0,1'b1,1'b0,1'b0,1'b1, 8'h77, 1'b0, 8'h00, 1'b0}, // R3 R8 continue+stop
    '{SA,  1'b1,1'b0,1'b0,1'b0,1'b1, 8'h00, 1'b0, 8'h00, 1'b0}, // R7 probe ack
    '{BAD, 1'b1,1'b0,1'b0,1'b0,1'b1, 8'h00, 1'b1, 8'h00, 1'b0}, // R6 R7 probe nak
    '{SA,  1'b1,1'b1,1'b0,1'b0,1'b1, 8'hFF, 1'b1, 8'h00, 1'b0}, // R6 data nak
    '{SA,  1'b1,1'b0,1'b1,1'b0,1'b0, 8'h00, 1'b0, 8'hA5, 1'b1}, // R4 read
    '{SA,  1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 1'b0, 8'hA6, 1'b1}, // R4 read
    '{SA,  1'b0,1'b0,1'b1,1'b1,1'b1, 8'h00, 1'b0, 8'hA7, 1'b0}, // R4 last read
    '{SA,  1'b1,1'b1,1'b0,1'b0,1'b0, 8'h10, 1'b0, 8'h00, 1'b1}, // R2 write
    '{SA,  1'b1,1'b0,1'b1,1'b1,1'b1, 8'h00, 1'b0, 8'hA5, 1'b0}  // R2 repeated start
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int st0, sp0;
    n_chk = 0; n_err = 0; finished = 1'b0;
    cmd_we = 1'b0; buf_we = 1'b0; sts_we = 1'b0;
    cmd_wdata = 32'h0; buf_wdata = 32'h0; sts_wdata = 32'h0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 and R5 reset state
    chk("R5 status after reset", sts_rdata, 32'h0);
    chk("R9 buffer after reset", buf_rdata, 32'h0);
    chk("R10 scl released after reset", {31'h0, scl_oe}, 32'h0);
    chk("R10 sda released after reset", {31'h0, sda_oe}, 32'h0);

    for (int i = 0; i < 10; i++) begin
      wr_buf(VEC[i].txb);
      wr_cmd(mk_cmd(1'b1, VEC[i].addr, VEC[i].st, VEC[i].tx, VEC[i].rx, VEC[i].last, VEC[i].sp));
      wait_done($sformatf("R5 vec%0d", i));
      chk($sformatf("R6 vec%0d nak", i), {31'h0, sts_rdata[1]}, {31'h0, VEC[i].nak});
      chk($sformatf("R9 vec%0d busy", i), {31'h0, buf_rdata[16]}, {31'h0, VEC[i].busy});
      if (VEC[i].rx)
        chk($sformatf("R4 vec%0d rx byte", i), {24'h0, buf_rdata[15:8]}, {24'h0, VEC[i].rxv});
      if (VEC[i].tx)
        chk($sformatf("R3 vec%0d target saw byte", i), {24'h0, sl_last_wr}, {24'h0, VEC[i].txb});
      wr_sts(32'h0001_0002);
    end
    chk("R2 start count incl repeated start", sl_starts, 7);
    chk("R2 stop count", sl_stops, 6);
    chk("R10 lines released after stop", {30'h0, scl_oe, sda_oe}, 32'h0);

    // R1: enable bit clear
    st0 = sl_starts;
    wr_cmd(mk_cmd(1'b0, SA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    repeat (300) @(negedge clk);
    chk("R1 disabled cmd no done", sts_rdata, 32'h0);
    chk("R1 disabled cmd no start", sl_starts, st0);
    chk("R1 disabled cmd lines idle", {30'h0, scl_oe, sda_oe}, 32'h0);

    // R1: command while busy is ignored
    wr_cmd(mk_cmd(1'b1, SA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    repeat (20) @(negedge clk);
    wr_cmd(mk_cmd(1'b1, BAD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    wait_done("R1 busy first");
    chk("R1 first packet kept its address", sts_rdata, 32'h0001_0000);
    wr_sts(32'h0001_0000);
    repeat (400) @(negedge clk);
    chk("R1 second command dropped", sts_rdata, 32'h0);
    chk("R1 only one start", sl_starts, st0 + 1);

    // R5/R6: separate write-one-to-clear
    wr_cmd(mk_cmd(1'b1, BAD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    wait_done("R6 nak probe");
    wr_sts(32'h0000_0000);
    chk("R5 writing zero keeps flags", sts_rdata, 32'h0001_0002);
    wr_sts(32'h0000_0002);
    chk("R6 nak cleared alone", sts_rdata, 32'h0001_0000);
    wr_sts(32'h0001_0000);
    chk("R5 done cleared", sts_rdata, 32'h0);

    // R8: nak without stop holds SCL low
    sp0 = sl_stops;
    wr_cmd(mk_cmd(1'b1, BAD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    wait_done("R8 nak no stop");
    repeat (100) @(negedge clk);
    chk("R8 scl held low after nak", {31'h0, scl_oe}, 32'h1);
    chk("R9 busy after nak without stop", {31'h0, buf_rdata[16]}, 32'h1);
    chk("R8 no stop sent", sl_stops, sp0);
    wr_sts(32'h0001_0002);
    wr_cmd(mk_cmd(1'b1, SA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    wait_done("R8 stop only");
    chk("R8 stop issued", sl_stops, sp0 + 1);
    chk("R9 busy clear after stop", {31'h0, buf_rdata[16]}, 32'h0);
    chk("R10 lines released after stop only", {30'h0, scl_oe, sda_oe}, 32'h0);

    finish_run();
  end

endmodule